// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block sits between a programmed master request and a separate bit-level I2C engine. When it accepts a request, it breaks the request into bus primitives: start, address, one command per data byte (write, read-with-acknowledge, read-with-not-acknowledge) and stop. It hands these to the engine one at a time over a valid/ready handshake. The engine reports whether the slave acknowledged each address or write byte. The sequencer does not model SCL/SDA timing, clock division or arbitration.

The request carries a direction, a byte count, an address and three ending controls: halt, repeated start and chain. These controls decide how the transfer finishes, under a fixed priority:

- Halt releases the bus with a stop.
- Repeated start keeps the bus without a stop and parks the interface in a waiting state, so the next request opens with a repeated start.
- Chain parks the interface in a paused state, so the next request carries on with data bytes alone.
- With none of the three, the transfer closes with a stop.

A halt raised while a transfer is running abandons the outstanding primitive and forces a stop. The block has no timeout of its own, so that halt and the reset are the only ways out of a hung bus.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset the interface state is stopped (code 0), no command is valid, done is low and the status is OK (code 0).
- R2: A request accepted in the stopped (0) or waiting (2) state issues START (command 0), then ADDR (command 1) with the address byte equal to {address, read flag}. A request accepted in the paused (3) state issues neither, and begins directly with data commands.
- R3: A byte-count field of value k produces exactly k+1 data commands. WRITE is command 2. READ_ACK is command 3 and READ_NACK is command 4.
- R4: On a read, every data command is READ_ACK except the last, which is READ_NACK. This happens before the ending action.
- R5: A request made with halt set ends, after its last byte, with STOP (command 5) and the stopped state, whatever the repeated-start and chain bits say.
- R6: With halt clear and repeated start set, the transfer ends without STOP. The interface goes to the waiting state (2) whatever chain says.
- R7: With only chain set, the transfer ends without STOP and the interface goes to the paused state (3).
- R8: With no ending bit set, the transfer ends with STOP and the stopped state. The active state is code 1 while a request is running.
- R9: A slave not-acknowledge on ADDR or on a WRITE byte causes the next command to be STOP, with no further data commands. The transfer then ends in the stopped state with status NACK (code 1).
- R10: A go pulse while the interface is active has no effect on the running command sequence, and sets status to BUSY (code 2) until the running transfer completes.
- R11: A halt pulse while a START, ADDR or data command is outstanding abandons that command. The next command is STOP, and the transfer ends stopped with status HALTED (code 3).
- R12: A command stays valid and unchanged until ready, unless a halt intervenes. Done is a one-cycle pulse per accepted request, raised in the cycle after the final handshake. Status and interface state are updated in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Request strobe |
| rd_i | input | 1 | 1 = read, 0 = write |
| cnt_i | input | CNT_W | Byte count minus one |
| addr_i | input | ADDR_W | Slave address |
| chain_i | input | 1 | Chain ending request |
| rstart_i | input | 1 | Repeated-start ending request |
| halt_i | input | 1 | Halt: ending selector at go, abort while active |
| cmd_valid_o | output | 1 | Command valid to the bit engine |
| cmd_o | output | 3 | Primitive code |
| addr_byte_o | output | ADDR_W+1 | Address byte for ADDR |
| cmd_ready_i | input | 1 | Engine has completed the command |
| ack_i | input | 1 | Slave acknowledged (ADDR/WRITE), valid with ready |
| iface_o | output | 2 | Interface state |
| status_o | output | 2 | Status code |
| done_o | output | 1 | Request complete pulse |

## Verification
The bench builds the block with its default parameters: CNT_W = 2, so 1 to 4 bytes, and ADDR_W = 7. Every byte-count value is therefore reachable, including the single-byte read, where the first data command is already READ_NACK. State carries over from one request to the next, so random sequences reach every interface state as a starting point, in particular the paused start with no START/ADDR. Engine latency is random, and slave not-acknowledge positions are random. Directed cases cover busy go, live halt against a stalled engine, and the address not-acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {
    IF_STOPPED = 2'd0,
    IF_ACTIVE  = 2'd1,
    IF_WAITING = 2'd2,
    IF_PAUSED  = 2'd3
  } iface_e;

  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_ADDR    = 3'd1,
    CMD_WR      = 3'd2,
    CMD_RD_ACK  = 3'd3,
    CMD_RD_NACK = 3'd4,
    CMD_STOP    = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_NACK = 2'd1,
    ST_BUSY = 2'd2,
    ST_HALT = 2'd3
  } stat_e;

  typedef enum logic [1:0] {
    END_STOP  = 2'd0,
    END_WAIT  = 2'd1,
    END_PAUSE = 2'd2
  } ending_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_ADDR  = 3'd2,
    S_DATA  = 3'd3,
    S_STOP  = 3'd4
  } seq_e;
endpackage

// File: rtl/i2cs_end_sel.sv
module i2cs_end_sel
  import i2cs_pkg::*;
(
  input  logic    halt_i,
  input  logic    rstart_i,
  input  logic    chain_i,
  output ending_e ending_o
);
  // Fixed priority: halt, then repeated start, then chain.
  always_comb begin
    if (halt_i)        ending_o = END_STOP;
    else if (rstart_i) ending_o = END_WAIT;
    else if (chain_i)  ending_o = END_PAUSE;
    else               ending_o = END_STOP;
  end
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              chain_i,
  input  logic              rstart_i,
  input  logic              halt_i,
  input  logic              cmd_ready_i,
  input  logic              ack_i,
  input  ending_e           ending_i,
  output logic              sel_halt_o,
  output logic              sel_rstart_o,
  output logic              sel_chain_o,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [ADDR_W:0]   addr_byte_o,
  output iface_e            iface_o,
  output stat_e             status_o,
  output logic              done_o
);
  seq_e              st_q, st_d;
  iface_e            if_q, if_d;
  stat_e             stat_q, stat_d, pend_q, pend_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic              rd_q, rd_d, ch_q, ch_d, rs_q, rs_d, hl_q, hl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fire;

  assign fire         = (st_q != S_IDLE) && cmd_ready_i;
  assign sel_halt_o   = hl_q;
  assign sel_rstart_o = rs_q;
  assign sel_chain_o  = ch_q;

  always_comb begin
    st_d = st_q;  if_d = if_q;  stat_d = stat_q;  pend_d = pend_q;
    done_d = 1'b0; idx_d = idx_q; last_d = last_q;
    rd_d = rd_q;  ch_d = ch_q;  rs_d = rs_q;  hl_d = hl_q;  addr_d = addr_q;
    unique case (st_q)
      S_IDLE: begin
        if (go_i) begin
          rd_d = rd_i;  ch_d = chain_i;  rs_d = rstart_i;  hl_d = halt_i;
          addr_d = addr_i;  last_d = cnt_i;  idx_d = '0;
          stat_d = ST_OK;  pend_d = ST_OK;  if_d = IF_ACTIVE;
          st_d = (if_q == IF_PAUSED) ? S_DATA : S_START;
        end
      end
      S_START, S_ADDR, S_DATA: begin
        if (halt_i) begin
          st_d = S_STOP;  pend_d = ST_HALT;
        end else if (fire) begin
          if (st_q == S_START) st_d = S_ADDR;
          else if (st_q == S_ADDR) begin
            if (ack_i) st_d = S_DATA;
            else begin st_d = S_STOP; pend_d = ST_NACK; end
          end else if (!rd_q && !ack_i) begin
            st_d = S_STOP;  pend_d = ST_NACK;
          end else if (idx_q == last_q) begin
            unique case (ending_i)
              END_WAIT:  begin st_d = S_IDLE; if_d = IF_WAITING; done_d = 1'b1; stat_d = pend_q; end
              END_PAUSE: begin st_d = S_IDLE; if_d = IF_PAUSED;  done_d = 1'b1; stat_d = pend_q; end
              default:   st_d = S_STOP;
            endcase
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (fire) begin
          st_d = S_IDLE;  if_d = IF_STOPPED;  done_d = 1'b1;  stat_d = pend_q;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (go_i && if_q == IF_ACTIVE && !done_d) stat_d = ST_BUSY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  if_q <= IF_STOPPED;  stat_q <= ST_OK;  pend_q <= ST_OK;
      done_q <= 1'b0;  idx_q <= '0;  last_q <= '0;
      rd_q <= 1'b0;  ch_q <= 1'b0;  rs_q <= 1'b0;  hl_q <= 1'b0;  addr_q <= '0;
    end else begin
      st_q <= st_d;  if_q <= if_d;  stat_q <= stat_d;  pend_q <= pend_d;
      done_q <= done_d;  idx_q <= idx_d;  last_q <= last_d;
      rd_q <= rd_d;  ch_q <= ch_d;  rs_q <= rs_d;  hl_q <= hl_d;  addr_q <= addr_d;
    end
  end

  always_comb begin
    unique case (st_q)
      S_START: cmd_o = CMD_START;
      S_ADDR:  cmd_o = CMD_ADDR;
      S_DATA:  cmd_o = !rd_q ? CMD_WR : ((idx_q == last_q) ? CMD_RD_NACK : CMD_RD_ACK);
      default: cmd_o = CMD_STOP;
    endcase
  end

  assign cmd_valid_o = (st_q != S_IDLE);
  assign addr_byte_o = {addr_q, rd_q};
  assign iface_o     = if_q;
  assign status_o    = stat_q;
  assign done_o      = done_q;

  assert_start_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid_o) && cmd_o == CMD_START) |->
      ($past(if_q) == IF_STOPPED || $past(if_q) == IF_WAITING));

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_o == CMD_STOP && cmd_ready_i) |=> (if_q == IF_STOPPED && done_o));

  assert_wait_nostop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (if_q == IF_WAITING && $past(if_q) == IF_ACTIVE) |-> ($past(cmd_o) != CMD_STOP));

  assert_halt_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && cmd_valid_o && cmd_o != CMD_STOP) |=> (cmd_valid_o && cmd_o == CMD_STOP));

  assert_valid_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cmd_valid_o && if_q != IF_ACTIVE));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int CNT_W  = 2,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              chain_i,
  input  logic              rstart_i,
  input  logic              halt_i,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W:0]   addr_byte_o,
  input  logic              cmd_ready_i,
  input  logic              ack_i,
  output logic [1:0]        iface_o,
  output logic [1:0]        status_o,
  output logic              done_o
);
  import i2cs_pkg::*;

  ending_e ending;
  logic    sel_halt, sel_rstart, sel_chain;
  cmd_e    cmd;
  iface_e  ifc;
  stat_e   stat;

  i2cs_end_sel u_end (
    .halt_i   (sel_halt),
    .rstart_i (sel_rstart),
    .chain_i  (sel_chain),
    .ending_o (ending)
  );

  i2cs_fsm #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go_i),
    .rd_i         (rd_i),
    .cnt_i        (cnt_i),
    .addr_i       (addr_i),
    .chain_i      (chain_i),
    .rstart_i     (rstart_i),
    .halt_i       (halt_i),
    .cmd_ready_i  (cmd_ready_i),
    .ack_i        (ack_i),
    .ending_i     (ending),
    .sel_halt_o   (sel_halt),
    .sel_rstart_o (sel_rstart),
    .sel_chain_o  (sel_chain),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_o        (cmd),
    .addr_byte_o  (addr_byte_o),
    .iface_o      (ifc),
    .status_o     (stat),
    .done_o       (done_o)
  );

  assign cmd_o    = cmd;
  assign iface_o  = ifc;
  assign status_o = stat;
endmodule

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 2;
  localparam int ADDR_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, rd = 1'b0, chain = 1'b0, rstart = 1'b0, halt = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic cmd_valid, ready = 1'b0, ack = 1'b1, done;
  logic [2:0] cmd;
  logic [ADDR_W:0] addr_byte;
  logic [1:0] iface, status;

  int checks = 0, fails = 0;
  int trc [0:15];
  int tn = 0;
  int dly = 0, wr_cnt = 0, nack_pos = -1;
  int got_addr = 0;
  bit hold = 1'b0;
  int exp_seq [0:15];
  int exp_n, exp_if, exp_st;
  int cur_if = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .go_i(go), .rd_i(rd), .cnt_i(cnt), .addr_i(addr),
    .chain_i(chain), .rstart_i(rstart), .halt_i(halt),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .addr_byte_o(addr_byte),
    .cmd_ready_i(ready), .ack_i(ack), .iface_o(iface), .status_o(status), .done_o(done)
  );

  // Responder standing in for the bit engine
  always @(negedge clk) begin
    if (rst_n) begin
      if (ready) begin
        ready = 1'b0;
        dly = $urandom % 3;
      end else if (cmd_valid && !hold) begin
        if (dly == 0) begin
          ready = 1'b1;
          ack = 1'b1;
          if (tn < 16) trc[tn] = int'(cmd);
          tn++;
          if (cmd == 3'd1) begin
            ack = (nack_pos != 0);
            got_addr = int'(addr_byte);
          end else if (cmd == 3'd2) begin
            ack = (nack_pos != wr_cnt + 1);
            wr_cnt++;
          end
        end else dly--;
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic compute_exp(input int ifb, input bit r, input int n, input bit ch,
                             input bit rs, input bit hl, input int np);
    exp_n = 0; exp_st = 0;
    if (ifb == 0 || ifb == 2) begin
      exp_seq[exp_n++] = 0; exp_seq[exp_n++] = 1;
      if (np == 0) begin exp_seq[exp_n++] = 5; exp_if = 0; exp_st = 1; return; end
    end
    for (int i = 0; i < n; i++) begin
      if (r) exp_seq[exp_n++] = (i == n-1) ? 4 : 3;
      else begin
        exp_seq[exp_n++] = 2;
        if (np == i+1) begin exp_seq[exp_n++] = 5; exp_if = 0; exp_st = 1; return; end
      end
    end
    if (hl)      begin exp_seq[exp_n++] = 5; exp_if = 0; end
    else if (rs) exp_if = 2;
    else if (ch) exp_if = 3;
    else         begin exp_seq[exp_n++] = 5; exp_if = 0; end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int t = 0; t < 200; t++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; return; end
    end
  endtask

  task automatic start_go(input bit r, input int n, input bit ch, input bit rs,
                          input bit hl, input int np, input logic [ADDR_W-1:0] a);
    tn = 0; wr_cnt = 0; nack_pos = np; got_addr = -1;
    @(negedge clk);
    go = 1'b1; rd = r; cnt = CNT_W'(n-1); chain = ch; rstart = rs; halt = hl; addr = a;
    @(negedge clk);
    go = 1'b0; chain = 1'b0; rstart = 1'b0; halt = 1'b0;
  endtask

  task automatic finish_check(input bit r, input int n, input bit ch, input bit rs,
                              input bit hl, input int np, input logic [ADDR_W-1:0] a);
    string tag;
    bit ok, had_addr;
    had_addr = (cur_if == 0 || cur_if == 2);
    compute_exp(cur_if, r, n, ch, rs, hl, np);
    if (exp_st == 1) tag = "R9";
    else if (hl) tag = "R5";
    else if (rs) tag = "R6";
    else if (ch) tag = "R7";
    else tag = "R8";
    wait_done(ok);
    check("R12", "done seen", int'(ok), 1);
    check("R2/R3/R4", "command count", tn, exp_n);
    for (int i = 0; i < exp_n && i < tn && i < 16; i++)
      check("R2/R3/R4", "command", trc[i], exp_seq[i]);
    if (had_addr) check("R2", "address byte", got_addr, int'({a, r}));
    check(tag, "iface", int'(iface), exp_if);
    check(tag, "status", int'(status), exp_st);
    @(negedge clk);
    check("R12", "done width", int'(done), 0);
    cur_if = int'(iface);
  endtask

  task automatic run_xfer(input bit r, input int n, input bit ch, input bit rs,
                          input bit hl, input int np);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'($urandom);
    start_go(r, n, ch, rs, hl, np, a);
    finish_check(r, n, ch, rs, hl, np, a);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", "iface", int'(iface), 0);
    check("R1", "valid", int'(cmd_valid), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "status", int'(status), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_xfer(1'b0, 2, 0, 0, 0, -1);   // R8 plain write
    run_xfer(1'b1, 4, 1, 0, 0, -1);   // R7 R4 chained read
    run_xfer(1'b0, 1, 1, 1, 0, -1);   // R2 from paused, R6 beats chain
    run_xfer(1'b1, 1, 1, 1, 1, -1);   // R5 halt beats all, R4 single byte
    run_xfer(1'b0, 3, 0, 0, 0, 0);    // R9 address nack
    run_xfer(1'b0, 4, 0, 0, 0, 2);    // R9 write nack on second byte

    // R10: go while active is ignored
    hold = 1'b1;
    start_go(1'b0, 2, 0, 0, 0, -1, 7'h2a);
    repeat (2) @(negedge clk);
    go = 1'b1; rd = 1'b1; cnt = 2'd3; chain = 1'b1;
    @(negedge clk);
    go = 1'b0; rd = 1'b0; chain = 1'b0;
    check("R10", "busy status", int'(status), 2);
    check("R10", "still active", int'(iface), 1);
    hold = 1'b0;
    finish_check(1'b0, 2, 0, 0, 0, -1, 7'h2a);

    // R11: live halt against a stalled engine
    hold = 1'b1;
    start_go(1'b0, 3, 0, 0, 0, -1, 7'h11);
    repeat (3) @(negedge clk);
    check("R12", "command held", int'(cmd_valid), 1);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    check("R11", "stop issued", int'(cmd), 5);
    hold = 1'b0;
    wait_done(ok);
    check("R11", "done", int'(ok), 1);
    check("R11", "only stop", tn, 1);
    if (tn > 0) check("R11", "stop command", trc[0], 5);
    check("R11", "iface", int'(iface), 0);
    check("R11", "status", int'(status), 3);
    @(negedge clk);
    cur_if = int'(iface);

    for (int k = 0; k < 60; k++) begin
      bit r, ch, rs, hl;
      int n, np;
      r  = 1'($urandom);
      n  = ($urandom % 4) + 1;
      ch = ($urandom % 2) == 0;
      rs = ($urandom % 3) == 0;
      hl = ($urandom % 5) == 0;
      np = (($urandom % 5) == 0) ? int'($urandom % (n + 1)) : -1;
      run_xfer(r, n, ch, rs, hl, np);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule